// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block collects 64 interrupt sources and drives two active-high request lines toward a processor: a normal request line and a fast request line. Each source is configured through a small synchronous register port (address, write strobe, write data, combinational read data). Configuration covers:

- whether the source is level or edge sensitive;
- its active polarity or edge direction;
- whether an edge source reacts to both edges;
- which of the two outputs it feeds;
- whether it is enabled.

Software can also force any source active.

Sources are grouped into two 32-bit banks. Source n lives in bank n>>5 at bit n&31. Every register has its low-bank word at a base offset and its high-bank word at base+4, and the registers are spaced 8 bytes apart. Edge sources capture the detected edge in a latch that stays set until software clears it. Level sources pass straight through to status after the polarity adjustment.

Top module: `dual_bank_intc`

## Requirements
- R1: Register words sit at base offsets 0x00 normal-status, 0x08 fast-status, 0x10 raw-status, 0x18 route, 0x20 enable-set, 0x28 enable-clear, 0x30 force-set, 0x38 force-clear, 0x40 level-mode, 0x48 both-edges, 0x50 polarity, 0x58 latch-clear and 0x60 latch-status. The high bank is at base+4, and source n maps to bank n>>5, bit n&31. After reset, polarity reads all ones and every other register reads zero.
- R2: Writing 1 to a bit of enable-set enables that source, and writing 1 to it in enable-clear disables it. Zero bits in either write leave the enable unchanged. Reading enable-set returns the enable mask.
- R3: Writing 1 to a bit of force-set makes that source pending regardless of its input. Writing 1 to that bit in force-clear removes the forcing.
- R4: A route bit of 0 sends the pending, enabled source to the normal output. A route bit of 1 sends it to the fast output.
- R5: A level-mode bit of 1 makes the source level sensitive. It is active when the input equals its polarity bit (1 = active high, 0 = active low), and the status and outputs follow the input in the same cycle.
- R6: A level-mode bit of 0 makes the source edge sensitive. The latch sets on a rising edge when polarity is 1 and on a falling edge when polarity is 0, and it holds until a 1 is written to that bit of latch-clear.
- R7: A both-edges bit of 1 makes an edge source latch on rising and on falling edges.
- R8: A latch-clear write has no effect on a level source. When a new edge and a latch-clear write for the same source meet in one cycle, the latch stays set.
- R9: Raw status shows each source's active state before enable and routing: the latch for edge sources and the polarity-adjusted input for level sources. Latch-status shows the edge latches.
- R10: The normal output is the OR of all 64 normal-status bits, and the fast output is the OR of all 64 fast-status bits. A pending bit is (active OR forced) AND enabled, split by route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| src_i | input | 64 | Interrupt source inputs |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The two functions that can meet in one clock are edge capture on a source and a software latch-clear write to that same source.

The bench provokes this in one test:
- It first latches an edge and then returns the input low.
- On the same falling clock edge it raises the input again and presents the latch-clear write, so the new rising edge and the clear reach the latch in the same cycle.

The test passes when the latch-status bit and the normal output are still set after that clock, which confirms that the new event survives the clear.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [3:0] {
    REG_IRQ_ST  = 4'd0,
    REG_FIQ_ST  = 4'd1,
    REG_RAW_ST  = 4'd2,
    REG_ROUTE   = 4'd3,
    REG_EN_SET  = 4'd4,
    REG_EN_CLR  = 4'd5,
    REG_SW_SET  = 4'd6,
    REG_SW_CLR  = 4'd7,
    REG_LEVEL   = 4'd8,
    REG_BOTH    = 4'd9,
    REG_POL     = 4'd10,
    REG_LAT_CLR = 4'd11,
    REG_LAT_ST  = 4'd12
  } reg_idx_e;

  localparam int unsigned IDX_LSB = 3;  // 8-byte register stride
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned BANK_BIT = 2; // high bank at +4
endpackage

// File: rtl/intc_edge_det.sv
module intc_edge_det #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= src_i;
  end

  assign rise  = src_i & ~prev_q;
  assign fall  = ~src_i & prev_q;
  assign hit_o = (both_i & (rise | fall))
               | (~both_i & pol_i & rise)
               | (~both_i & ~pol_i & fall);
endmodule

// File: rtl/intc_src_bank.sv
module intc_src_bank
  import intc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         wr_i,
  input  reg_idx_e     idx_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] irq_stat_o,
  output logic [W-1:0] fiq_stat_o
);
  logic [W-1:0] en_q, sel_q, sw_q, lvl_q, both_q, pol_q, lat_q;
  logic [W-1:0] hit, lat_clr, lat_d, lvl_act, active, pend;

  intc_edge_det #(.W(W)) edge_det_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .both_i (both_q),
    .pol_i  (pol_q),
    .hit_o  (hit)
  );

  assign lat_clr = (wr_i && idx_i == REG_LAT_CLR) ? wdata_i : '0;
  // new edge beats a simultaneous clear; level sources keep no latch
  assign lat_d   = ((lat_q & ~lat_clr) | hit) & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      sel_q  <= '0;
      sw_q   <= '0;
      lvl_q  <= '0;
      both_q <= '0;
      pol_q  <= '1;
      lat_q  <= '0;
    end else begin
      lat_q <= lat_d;
      if (wr_i) begin
        unique case (idx_i)
          REG_ROUTE:  sel_q  <= wdata_i;
          REG_EN_SET: en_q   <= en_q | wdata_i;
          REG_EN_CLR: en_q   <= en_q & ~wdata_i;
          REG_SW_SET: sw_q   <= sw_q | wdata_i;
          REG_SW_CLR: sw_q   <= sw_q & ~wdata_i;
          REG_LEVEL:  lvl_q  <= wdata_i;
          REG_BOTH:   both_q <= wdata_i;
          REG_POL:    pol_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign lvl_act    = ~(src_i ^ pol_q);
  assign active     = (lvl_q & lvl_act) | (~lvl_q & lat_q);
  assign pend       = (active | sw_q) & en_q;
  assign irq_stat_o = pend & ~sel_q;
  assign fiq_stat_o = pend & sel_q;

  always_comb begin
    unique case (idx_i)
      REG_IRQ_ST: rdata_o = irq_stat_o;
      REG_FIQ_ST: rdata_o = fiq_stat_o;
      REG_RAW_ST: rdata_o = active;
      REG_ROUTE:  rdata_o = sel_q;
      REG_EN_SET: rdata_o = en_q;
      REG_SW_SET: rdata_o = sw_q;
      REG_LEVEL:  rdata_o = lvl_q;
      REG_BOTH:   rdata_o = both_q;
      REG_POL:    rdata_o = pol_q;
      REG_LAT_ST: rdata_o = lat_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned BANK_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [BANK_W-1:0]  wdata_i,
  output logic [BANK_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic               fiq_o
);
  // the +4 interleave holds exactly two banks
  localparam int unsigned NUM_BANKS = NUM_SRC / BANK_W;
  localparam int unsigned TOP_LSB   = IDX_LSB + IDX_W;

  logic              addr_ok;
  logic              bank_sel;
  reg_idx_e          idx;
  logic [BANK_W-1:0] bank_rd [NUM_BANKS];
  logic [NUM_SRC-1:0] irq_all, fiq_all;

  assign addr_ok  = (addr_i >> TOP_LSB) == '0;
  assign bank_sel = addr_i[BANK_BIT];
  assign idx      = reg_idx_e'(addr_i[IDX_LSB +: IDX_W]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr;
    assign wr = we_i && addr_ok && (bank_sel == b[0]);

    intc_src_bank #(.W(BANK_W)) bank_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i[b*BANK_W +: BANK_W]),
      .wr_i       (wr),
      .idx_i      (idx),
      .wdata_i    (wdata_i),
      .rdata_o    (bank_rd[b]),
      .irq_stat_o (irq_all[b*BANK_W +: BANK_W]),
      .fiq_stat_o (fiq_all[b*BANK_W +: BANK_W])
    );
  end

  assign rdata_o = addr_ok ? bank_rd[bank_sel] : '0;
  assign irq_o   = |irq_all;
  assign fiq_o   = |fiq_all;
endmodule

// File: rtl/intc_bank_chk.sv
module intc_bank_chk
  import intc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_i,
  input reg_idx_e     idx_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] en_q,
  input logic [W-1:0] sel_q,
  input logic [W-1:0] sw_q,
  input logic [W-1:0] lvl_q,
  input logic [W-1:0] lat_q,
  input logic [W-1:0] irq_stat_o,
  input logic [W-1:0] fiq_stat_o
);
  // R2
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == REG_EN_SET) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

  // R2
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == REG_EN_CLR) |=> ((en_q & $past(wdata_i)) == '0));

  // R6
  lat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && idx_i == REG_LAT_CLR) |=> ((~$past(lvl_q) & $past(lat_q) & ~lat_q) == '0));

  // R8
  lvl_no_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lvl_q) |=> (($past(lvl_q) & lat_q) == '0));

  // R3
  sw_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sw_q & en_q & ~sel_q)) |-> (|irq_stat_o));

  // R4
  fiq_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fiq_stat_o) |-> (|(en_q & sel_q)));
endmodule

bind intc_src_bank intc_bank_chk #(.W(W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .idx_i      (idx_i),
  .wdata_i    (wdata_i),
  .en_q       (en_q),
  .sel_q      (sel_q),
  .sw_q       (sw_q),
  .lvl_q      (lvl_q),
  .lat_q      (lat_q),
  .irq_stat_o (irq_stat_o),
  .fiq_stat_o (fiq_stat_o)
);

// File: tb/dual_bank_intc_tb_top.sv
`timescale 1ns/1ps
module dual_bank_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src = '0;
  logic        irq, fiq;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dual_bank_intc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .src_i(src), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk);
    src[i] = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h50, d); chk("R1 polarity low reset", d, 32'hFFFF_FFFF);
    rd(8'h54, d); chk("R1 polarity high reset", d, 32'hFFFF_FFFF);
    rd(8'h40, d); chk("R1 level reset", d, 32'h0);
    rd(8'h24, d); chk("R1 enable reset", d, 32'h0);
    chk("R1 outputs reset", {30'b0, irq, fiq}, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(8'h40, 32'h8);
    set_src(3, 1'b1);
    rd(8'h10, d); chk("R9 raw pre-enable", d, 32'h8);
    chk("R2 disabled no irq", {31'b0, irq}, 32'h0);
    wr(8'h20, 32'h8);
    chk("R2 enable irq", {31'b0, irq}, 32'h1);
    rd(8'h00, d); chk("R1 irq status low", d, 32'h8);
    wr(8'h20, 32'h0);
    wr(8'h28, 32'h0);
    rd(8'h20, d); chk("R2 zero writes ignored", d, 32'h8);
    wr(8'h28, 32'h8);
    chk("R2 disable irq", {31'b0, irq}, 32'h0);
    set_src(3, 1'b0);
    wr(8'h40, 32'h0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    wr(8'h44, 32'h100);
    set_src(40, 1'b1);
    wr(8'h24, 32'h100);
    wr(8'h1C, 32'h100);
    chk("R4 fast route", {30'b0, irq, fiq}, 32'h1);
    rd(8'h0C, d); chk("R1 fast status high bank", d, 32'h100);
    wr(8'h54, 32'hFFFF_FEFF);
    chk("R5 active-low idle", {31'b0, fiq}, 32'h0);
    @(negedge clk); src[40] = 1'b0; #1;
    chk("R5 active-low same cycle", {31'b0, fiq}, 32'h1);
    wr(8'h1C, 32'h0);
    chk("R4 normal route", {30'b0, irq, fiq}, 32'h2);
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h44, 32'h0);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    wr(8'h24, 32'h8000_0000);
    wr(8'h34, 32'h8000_0000);
    chk("R3 forced source", {31'b0, irq}, 32'h1);
    rd(8'h04, d); chk("R10 high-bank bit 63 drives irq", d, 32'h8000_0000);
    wr(8'h3C, 32'h8000_0000);
    chk("R3 force cleared", {31'b0, irq}, 32'h0);
    wr(8'h2C, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(8'h20, 32'h20);
    set_src(5, 1'b1);
    rd(8'h60, d); chk("R6 rising latched", d, 32'h20);
    chk("R6 irq from latch", {31'b0, irq}, 32'h1);
    set_src(5, 1'b0);
    rd(8'h10, d); chk("R6 latch held", d, 32'h20);
    wr(8'h58, 32'h20);
    chk("R6 cleared", {31'b0, irq}, 32'h0);
    wr(8'h50, 32'hFFFF_FFDF);
    set_src(5, 1'b1);
    rd(8'h60, d); chk("R6 rise ignored falling mode", d, 32'h0);
    set_src(5, 1'b0);
    rd(8'h60, d); chk("R6 falling latched", d, 32'h20);
    wr(8'h58, 32'h20);
    wr(8'h50, 32'hFFFF_FFFF);
  endtask

  task automatic t_dual();
    logic [31:0] d;
    wr(8'h48, 32'h20);
    set_src(5, 1'b1);
    rd(8'h60, d); chk("R7 rise latched", d, 32'h20);
    wr(8'h58, 32'h20);
    rd(8'h60, d); chk("R7 cleared", d, 32'h0);
    set_src(5, 1'b0);
    rd(8'h60, d); chk("R7 fall latched", d, 32'h20);
    wr(8'h58, 32'h20);
    wr(8'h48, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    set_src(5, 1'b1);
    set_src(5, 1'b0);
    @(negedge clk);
    src[5] = 1'b1; addr = 8'h58; we = 1'b1; wdata = 32'h20;
    @(negedge clk);
    we = 1'b0;
    rd(8'h60, d); chk("R8 edge beats clear", d, 32'h20);
    chk("R8 irq kept", {31'b0, irq}, 32'h1);
    wr(8'h58, 32'h20);
    wr(8'h28, 32'h20);
    wr(8'h40, 32'h80);
    wr(8'h20, 32'h80);
    set_src(7, 1'b1);
    wr(8'h58, 32'h80);
    rd(8'h00, d); chk("R8 level ignores clear", d, 32'h80);
    chk("R10 irq from level", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_route();
    t_soft();
    t_edge();
    t_dual();
    t_race();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule